// File: doc/BRIEF.md
# Tick Reload Timer

This block is a bus-attached countdown timer with three word registers: a control word, a 16-bit reload value and the live count. A fixed prescaler divides the system clock down to a 1 MHz tick. While the timer runs, every tick lowers the count by one. When the count is already zero, the next tick loads it again from the reload value, so the timer repeats with a period of reload + 1 ticks.

Software reaches the registers through a simple synchronous port. The port has a select, a write flag, a byte address inside a 256-byte window, and 32-bit write and read data. A read returns its data one cycle after the request.

The control word has two active bits. Bit 31 is a soft reset, and it wins over everything else in the same write. Bit 0 starts the timer, but clearing it never stops the timer. A write to the reload register also loads the live count at once.

Top module: `tick_reload_timer`

## Requirements
- R1: Registers sit at word-aligned byte offsets: control 0x00, reload 0x04, count 0x08. Any other address in the 0x00–0xFF window, including an address with bits [1:0] not zero, reads as zero, and a write to it changes no register.
- R2: `bus_rdata` is registered. It shows the read data in the cycle after a read request and is zero in any cycle that follows no read request.
- R3: After a hardware reset, control, reload and count all read zero and the timer is stopped.
- R4: A control write with bit 31 set stops the timer and clears control, reload and count to zero. The written value is not stored, and bit 0 of that write does not start the timer.
- R5: A control write with bit 31 clear and bit 0 set starts the timer, and the full 32-bit value is stored in control.
- R6: A control write with bit 0 clear stores the full value in control. A timer that is already running keeps counting.
- R7: A reload write keeps only bits [15:0]. Reading reload returns them zero-extended, and the same value is loaded into the count on the next clock edge, whether the timer is running or stopped.
- R8: A count read returns the 16-bit count zero-extended. A write to the count offset is ignored.
- R9: The prescaler issues exactly one tick every CLK_HZ/TICK_HZ clock cycles. While the timer runs, each tick lowers a non-zero count by one.
- R10: While the timer runs, a tick that finds the count at zero loads the reload value. With reload zero, the count stays at zero.
- R11: While the timer is stopped, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_sel | input | 1 | Access request in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The only place the internal state shows is in register reads, so every fault has to reach the read port. A run flag that is stuck or never set shows up within one tick period: two count reads exactly one period apart should differ by one, and they do not. A faulty wrap shows on the first tick after the count reaches zero, when the next read is not the reload value. A faulty soft-reset or reload-load path shows in the very next read of control, reload or count.

// File: rtl/trt_pkg.sv
package trt_pkg;
  localparam int DATA_W      = 32;
  localparam int CTRL_RST_BIT = 31;
  localparam int CTRL_EN_BIT  = 0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_COUNT
  } reg_sel_e;
endpackage

// File: rtl/trt_prescaler.sv
module trt_prescaler #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      localparam logic [PW-1:0] ONE  = PW'(1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          pcnt_q <= '0;
          tick_o <= 1'b0;
        end else begin
          tick_o <= (pcnt_q == LAST);
          if (pcnt_q == LAST) pcnt_q <= '0;
          else                pcnt_q <= pcnt_q + ONE;
        end
      end

      // R9
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end else begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) tick_o <= 1'b0;
        else     tick_o <= 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/trt_counter.sv
module trt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      run_q   <= 1'b0;
      count_q <= '0;
    end else begin
      if (start_i) run_q <= 1'b1;
      if (load_i) begin
        count_q <= load_val_i;
      end else if (run_q && tick_i) begin
        if (count_q == '0) count_q <= reload_i;
        else               count_q <= count_q - ONE;
      end
    end
  end

  assign count_o = count_q;

  // R4
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!run_q && count_q == '0));
  // R5
  start_run_chk: assert property (@(posedge clk) disable iff (rst)
    (start_i && !clr_i) |=> run_q);
  // R6
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !clr_i) |=> run_q);
  // R7
  reload_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clr_i) |=> count_q == $past(load_val_i));
  // R9
  decrement_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && !load_i && !clr_i && count_q != '0)
      |=> count_q == $past(count_q) - ONE);
  // R10
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick_i && !load_i && !clr_i && count_q == '0)
      |=> count_q == $past(reload_i));
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(run_q && tick_i) && !load_i && !clr_i) |=> $stable(count_q));
endmodule

// File: rtl/trt_regfile.sv
module trt_regfile
  import trt_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                CNT_W      = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 'h00,
  parameter logic [ADDR_W-1:0] RELOAD_OFS = 'h04,
  parameter logic [ADDR_W-1:0] COUNT_OFS  = 'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  output logic              soft_clr_o,
  output logic              start_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  reload_o
);
  localparam int PAD_W = DATA_W - CNT_W;

  reg_sel_e          hit;
  logic              aligned;
  logic              wr_ctrl;
  logic              rd_req;
  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;

  always_comb begin
    aligned = (addr_i[1:0] == 2'b00);
    hit     = SEL_NONE;
    if (aligned) begin
      if      (addr_i == CTRL_OFS)   hit = SEL_CTRL;
      else if (addr_i == RELOAD_OFS) hit = SEL_RELOAD;
      else if (addr_i == COUNT_OFS)  hit = SEL_COUNT;
    end
  end

  assign wr_ctrl    = sel_i && wr_i && (hit == SEL_CTRL);
  assign soft_clr_o = wr_ctrl && wdata_i[CTRL_RST_BIT];
  assign start_o    = wr_ctrl && !wdata_i[CTRL_RST_BIT] && wdata_i[CTRL_EN_BIT];
  assign load_o     = sel_i && wr_i && (hit == SEL_RELOAD);
  assign load_val_o = wdata_i[CNT_W-1:0];
  assign reload_o   = reload_q;
  assign rd_req     = sel_i && !wr_i;

  always_ff @(posedge clk) begin
    if (rst || soft_clr_o) begin
      ctrl_q   <= '0;
      reload_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q   <= wdata_i;
      if (load_o)  reload_q <= wdata_i[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !rd_req) begin
      rdata_o <= '0;
    end else begin
      case (hit)
        SEL_CTRL:   rdata_o <= ctrl_q;
        SEL_RELOAD: rdata_o <= {{PAD_W{1'b0}}, reload_q};
        SEL_COUNT:  rdata_o <= {{PAD_W{1'b0}}, count_i};
        default:    rdata_o <= '0;
      endcase
    end
  end

  // R1
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && hit == SEL_NONE) |=> rdata_o == '0);
  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> rdata_o == '0);
  // R4
  soft_reset_regs_chk: assert property (@(posedge clk) disable iff (rst)
    soft_clr_o |=> (ctrl_q == '0 && reload_q == '0));
  // R1
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_i && wr_i && hit == SEL_NONE) |=> ($stable(ctrl_q) && $stable(reload_q)));
endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer
  import trt_pkg::*;
#(
  parameter int                CLK_HZ     = 250_000_000,
  parameter int                TICK_HZ    = 1_000_000,
  parameter int                ADDR_W     = 8,
  parameter int                CNT_W      = 16,
  parameter logic [ADDR_W-1:0] CTRL_OFS   = 'h00,
  parameter logic [ADDR_W-1:0] RELOAD_OFS = 'h04,
  parameter logic [ADDR_W-1:0] COUNT_OFS  = 'h08
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int DIV = CLK_HZ / TICK_HZ;

  logic             tick;
  logic             soft_clr;
  logic             start;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] count;

  trt_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  trt_regfile #(
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .CTRL_OFS   (CTRL_OFS),
    .RELOAD_OFS (RELOAD_OFS),
    .COUNT_OFS  (COUNT_OFS)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .sel_i      (bus_sel),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .rdata_o    (bus_rdata),
    .count_i    (count),
    .soft_clr_o (soft_clr),
    .start_o    (start),
    .load_o     (load),
    .load_val_o (load_val),
    .reload_o   (reload_val)
  );

  trt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick),
    .clr_i      (soft_clr),
    .start_i    (start),
    .load_i     (load),
    .load_val_i (load_val),
    .reload_i   (reload_val),
    .count_o    (count)
  );
endmodule

// File: tb/test_tick_reload_timer.sv
`timescale 1ns/1ps
module test_tick_reload_timer;
  localparam int DIV = 250;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h00, 32'h0,          32'h0,          4'd3},  // R3 control
    '{1'b0, 8'h04, 32'h0,          32'h0,          4'd3},  // R3 reload
    '{1'b0, 8'h08, 32'h0,          32'h0,          4'd3},  // R3 count
    '{1'b1, 8'h00, 32'h1234_5670,  32'h0,          4'd6},  // R6 store, bit0 clear
    '{1'b0, 8'h00, 32'h0,          32'h1234_5670,  4'd6},
    '{1'b1, 8'h04, 32'hABCD_1234,  32'h0,          4'd7},  // R7 upper bits dropped
    '{1'b0, 8'h04, 32'h0,          32'h0000_1234,  4'd7},
    '{1'b0, 8'h08, 32'h0,          32'h0000_1234,  4'd7},  // R7 count loaded
    '{1'b1, 8'h08, 32'h0000_0077,  32'h0,          4'd8},  // R8 count write ignored
    '{1'b0, 8'h08, 32'h0,          32'h0000_1234,  4'd8},
    '{1'b1, 8'h40, 32'hFFFF_FFFF,  32'h0,          4'd1},  // R1 unmapped write
    '{1'b0, 8'h40, 32'h0,          32'h0,          4'd1},  // R1 unmapped read
    '{1'b0, 8'h00, 32'h0,          32'h1234_5670,  4'd1},
    '{1'b0, 8'h04, 32'h0,          32'h0000_1234,  4'd1},
    '{1'b0, 8'h06, 32'h0,          32'h0,          4'd1},  // R1 unaligned read
    '{1'b1, 8'h01, 32'h8000_0001,  32'h0,          4'd1},  // R1 unaligned write
    '{1'b0, 8'h00, 32'h0,          32'h1234_5670,  4'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  tick_reload_timer i_tick_reload_timer (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got cycle %0d expected finish earlier", cyc);
      summary();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] prev;
    logic [31:0] exp_next;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].data);
      else begin
        bus_read(VEC[i].addr, rd);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
      end
    end

    // R11: timer never started, count holds
    wait_cycles(3 * DIV);
    bus_read(8'h08, rd);
    check("R11 stopped hold", rd, 32'h0000_1234);

    // R2: rdata returns to zero after a read cycle
    @(negedge clk);
    check("R2 idle rdata", bus_rdata, 32'h0);

    // R5, R9, R10: periodic run with reload 3
    bus_write(8'h04, 32'h0000_0003);
    bus_write(8'h00, 32'h0000_0001);
    bus_read(8'h00, rd);
    check("R5 control stored", rd, 32'h0000_0001);
    bus_read(8'h08, prev);
    check("R10 count within reload", 32'(prev <= 32'd3), 32'd1);
    for (int s = 0; s < 8; s++) begin
      wait_cycles(DIV - 1);
      bus_read(8'h08, rd);
      exp_next = (prev == 32'd0) ? 32'd3 : prev - 32'd1;
      check("R9 R10 tick step", rd, exp_next);
      prev = rd;
    end

    // R6: clearing bit 0 does not stop; R7 reload while running
    bus_write(8'h00, 32'h0000_0000);
    bus_read(8'h00, rd);
    check("R6 control cleared", rd, 32'h0);
    bus_write(8'h04, 32'h0000_03E8);
    bus_read(8'h08, prev);
    check("R7 running load", 32'(prev == 32'd1000 || prev == 32'd999), 32'd1);
    wait_cycles(DIV - 1);
    bus_read(8'h08, rd);
    check("R6 still running", rd, prev - 32'd1);

    // R10: zero reload holds at zero while running
    bus_write(8'h04, 32'h0000_0000);
    wait_cycles(2 * DIV);
    bus_read(8'h08, rd);
    check("R10 zero reload", rd, 32'h0);

    // R4: soft reset wins over enable in the same write
    bus_write(8'h04, 32'h0000_0010);
    bus_write(8'h00, 32'h8000_0001);
    bus_read(8'h00, rd);
    check("R4 control cleared", rd, 32'h0);
    bus_read(8'h04, rd);
    check("R4 reload cleared", rd, 32'h0);
    bus_read(8'h08, rd);
    check("R4 count cleared", rd, 32'h0);
    bus_write(8'h04, 32'h0000_0032);
    wait_cycles(2 * DIV);
    bus_read(8'h08, rd);
    check("R4 timer stopped", rd, 32'h0000_0032);

    // R3: hardware reset during a run
    bus_write(8'h00, 32'h0000_0001);
    wait_cycles(DIV);
    @(negedge clk); rst = 1'b1;
    wait_cycles(2);
    rst = 1'b0;
    bus_read(8'h00, rd);
    check("R3 control after reset", rd, 32'h0);
    bus_read(8'h04, rd);
    check("R3 reload after reset", rd, 32'h0);
    bus_read(8'h08, rd);
    check("R3 count after reset", rd, 32'h0);
    bus_write(8'h04, 32'h0000_0014);
    wait_cycles(2 * DIV);
    bus_read(8'h08, rd);
    check("R3 stopped after reset", rd, 32'h0000_0014);

    summary();
  end
endmodule